// File: doc/BRIEF.md
# Secure Seconds Counter

This block keeps time for a battery-backed security domain. It holds a 47-bit count that advances once per tick of the 32.768 kHz low-power clock. The upper 32 bits are whole seconds and the lower 15 bits are the part of a second. Software reaches the block through a simple register port, with a single-cycle write and a combinational read. Through that port it loads the seconds and the fraction separately, arms an alarm, controls the run enable and the lock bits, and clears sticky status flags by writing ones to them.

The counter refuses to advance whenever its state cannot be trusted. That covers four cases: after a power loss until software has cleared the invalid flag and written a fresh seconds value, after a wrap of the full count, after a fault event, and while it is disabled. Lock bits guard both the count and the run enable against change. When the count reaches the alarm value, a sticky flag is raised, and that flag can drive an interrupt line.

Top module: `secure_sec_counter`

## Requirements
- R1: After reset the count reads 0, the control word (address 4) reads 0, the status word (address 5) reads 0x2 (only the invalid flag, bit 1), the alarm seconds (address 2) read 0xFFFFFFFF, the alarm fraction (address 3) and interrupt enable (address 6) read 0, and the interrupt is low.
- R2: The count rises by one per clock only while all of these hold: enable (control bit 3) is 1, the invalid flag (status bit 1) is 0, the overflow flag (status bit 2) is 0, the fault flag (status bit 0) is 0, and a seconds value has been accepted while the invalid flag was already clear. Otherwise the count holds.
- R3: A write to address 0 loads count bits 46:15 and keeps the fraction. A write to address 1 loads bits 14:0 from data bits 14:0 and keeps the seconds. A load takes priority over that cycle's increment. Seconds read at address 0, and the fraction reads zero-extended at address 1.
- R4: A count step from all ones gives zero and sets the overflow flag. The count then holds until that flag is cleared.
- R5: Control bit 17 (soft lock) and bit 18 (hard lock) are set by writing to address 4. While either is set, writes to addresses 0 and 1 and changes to the enable bit are ignored. A set hard lock stays set until reset and freezes the soft lock. A soft lock without a hard lock is cleared by writing 0 to it.
- R6: When the count equals {alarm seconds, alarm fraction}, the alarm flag (status bit 4) is set, unless the alarm seconds are all ones.
- R7: The interrupt output equals the alarm flag ANDed with the alarm interrupt enable (address 6, bit 4).
- R8: Writing a 1 to status bits 4, 2, 1 or 0 clears that flag. Writing a 0 leaves it unchanged. A set condition in the same cycle wins over the clear.
- R9: A high `fault_in` sets the fault flag (status bit 0), and counting stops while that flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-power tick clock |
| rst_n | input | 1 | Asynchronous active-low reset (power loss) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational |
| fault_in | input | 1 | Fault event, sets the fault flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
On every cycle the embedded properties check the following. The count holds whenever no load is present and no step is allowed. A wrap leaves the count at zero. A seconds load lands in bits 46:15. The overflow flag and the hard lock are sticky. A rising alarm flag always follows a match. A fault always raises the fault flag. The end-to-end behaviour can only be shown by the bench's scenarios comparing against its reference model each clock: the rule that a seconds write must come after the invalid flag is cleared, carry from fraction into seconds, a disarmed alarm staying quiet as the count passes through it, lock interplay with the enable bit, and resumption after each flag is cleared.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  // register addresses
  localparam logic [2:0] A_SEC   = 3'd0;
  localparam logic [2:0] A_FRAC  = 3'd1;
  localparam logic [2:0] A_ASEC  = 3'd2;
  localparam logic [2:0] A_AFRAC = 3'd3;
  localparam logic [2:0] A_CTRL  = 3'd4;
  localparam logic [2:0] A_STAT  = 3'd5;
  localparam logic [2:0] A_IEN   = 3'd6;
  // control bits
  localparam int B_EN   = 3;
  localparam int B_SOFT = 17;
  localparam int B_HARD = 18;
  // status bits
  localparam int B_FAIL = 0;
  localparam int B_NV   = 1;
  localparam int B_OVF  = 2;
  localparam int B_ALM  = 4;
  // interrupt enable bit
  localparam int B_AIE  = 4;
endpackage

// File: rtl/ssc_rst_sync.sv
module ssc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ssc_tick_counter.sv
module ssc_tick_counter #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic                      ld_sec,
  input  logic                      ld_frac,
  input  logic [SEC_W-1:0]          wdata,
  output logic [SEC_W+FRAC_W-1:0]   count,
  output logic                      wrap
);
  localparam int CNT_W = SEC_W + FRAC_W;

  logic [CNT_W-1:0] count_d;
  logic             cnt_ce;

  // step from all ones happens only when no load overrides it
  assign wrap = run & ~ld_sec & ~ld_frac & (&count);

  always_comb begin
    count_d = count;
    cnt_ce  = 1'b0;
    if (ld_sec) begin
      count_d[CNT_W-1:FRAC_W] = wdata;
      cnt_ce = 1'b1;
    end else if (ld_frac) begin
      count_d[FRAC_W-1:0] = wdata[FRAC_W-1:0];
      cnt_ce = 1'b1;
    end else if (run) begin
      count_d = count + CNT_W'(1);
      cnt_ce  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_ce) count <= count_d;
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_sec && !ld_frac) |=> $stable(count)); // R2
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0)); // R4
  AST_SEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_sec |=> (count[CNT_W-1:FRAC_W] == $past(wdata))); // R3
endmodule

// File: rtl/ssc_alarm_unit.sv
module ssc_alarm_unit #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_asec,
  input  logic                    wr_afrac,
  input  logic [SEC_W-1:0]        wdata,
  input  logic [SEC_W+FRAC_W-1:0] count,
  output logic [SEC_W-1:0]        alarm_sec,
  output logic [FRAC_W-1:0]       alarm_frac,
  output logic                    match
);
  logic [SEC_W-1:0]  asec_d;
  logic [FRAC_W-1:0] afrac_d;

  always_comb begin
    asec_d  = alarm_sec;
    afrac_d = alarm_frac;
    if (wr_asec)  asec_d  = wdata;
    if (wr_afrac) afrac_d = wdata[FRAC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_sec  <= '1;
      alarm_frac <= '0;
    end else begin
      if (wr_asec)  alarm_sec  <= asec_d;
      if (wr_afrac) alarm_frac <= afrac_d;
    end
  end

  // all-ones seconds leave the alarm disarmed
  assign match = (count == {alarm_sec, alarm_frac}) & ~(&alarm_sec);
endmodule

// File: rtl/ssc_ctrl_status.sv
module ssc_ctrl_status
  import ssc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_stat,
  input  logic              wr_ien,
  input  logic              ld_sec,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wrap,
  input  logic              match,
  input  logic              fault_in,
  output logic              run,
  output logic              locked,
  output logic [DATA_W-1:0] ctrl_word,
  output logic [DATA_W-1:0] stat_word,
  output logic [DATA_W-1:0] ien_word,
  output logic              irq
);
  logic en_q, soft_q, hard_q, aie_q;
  logic en_d, soft_d, hard_d, aie_d;
  logic nv_q, ovf_q, fail_q, alm_q, ld_q;
  logic nv_d, ovf_d, fail_d, alm_d, ld_d;
  logic cfg_ce;
  logic [DATA_W-1:0] w1c;
  logic unused_wdata;

  assign unused_wdata = ^wdata;
  assign locked = soft_q | hard_q;
  assign run    = en_q & ld_q & ~nv_q & ~ovf_q & ~fail_q;
  assign w1c    = wr_stat ? wdata : '0;
  assign cfg_ce = wr_ctrl | wr_ien;

  always_comb begin
    en_d   = en_q;
    soft_d = soft_q;
    hard_d = hard_q;
    aie_d  = aie_q;
    if (wr_ctrl) begin
      if (!locked) en_d = wdata[B_EN];
      if (!hard_q) begin
        soft_d = wdata[B_SOFT];
        hard_d = wdata[B_HARD];
      end
    end
    if (wr_ien) aie_d = wdata[B_AIE];
    alm_d  = match    | (alm_q  & ~w1c[B_ALM]);
    ovf_d  = wrap     | (ovf_q  & ~w1c[B_OVF]);
    nv_d   = nv_q     & ~w1c[B_NV];
    fail_d = fault_in | (fail_q & ~w1c[B_FAIL]);
    ld_d   = ld_q     | (ld_sec & ~nv_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      soft_q <= 1'b0;
      hard_q <= 1'b0;
      aie_q  <= 1'b0;
      nv_q   <= 1'b1;
      ovf_q  <= 1'b0;
      fail_q <= 1'b0;
      alm_q  <= 1'b0;
      ld_q   <= 1'b0;
    end else begin
      if (cfg_ce) begin
        en_q   <= en_d;
        soft_q <= soft_d;
        hard_q <= hard_d;
        aie_q  <= aie_d;
      end
      nv_q   <= nv_d;
      ovf_q  <= ovf_d;
      fail_q <= fail_d;
      alm_q  <= alm_d;
      ld_q   <= ld_d;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[B_EN]   = en_q;
    ctrl_word[B_SOFT] = soft_q;
    ctrl_word[B_HARD] = hard_q;
    stat_word = '0;
    stat_word[B_FAIL] = fail_q;
    stat_word[B_NV]   = nv_q;
    stat_word[B_OVF]  = ovf_q;
    stat_word[B_ALM]  = alm_q;
    ien_word = '0;
    ien_word[B_AIE]   = aie_q;
  end

  assign irq = alm_q & aie_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(wr_stat && wdata[B_OVF])) |=> ovf_q); // R4
  AST_HARD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hard_q |=> hard_q); // R5
  AST_ALARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_q) |-> $past(match)); // R6
  AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |=> fail_q); // R9
endmodule

// File: rtl/secure_sec_counter.sv
module secure_sec_counter
  import ssc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FRAC_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              fault_in,
  output logic              alarm_irq
);
  localparam int SEC_W = DATA_W;
  localparam int CNT_W = SEC_W + FRAC_W;

  logic             rst_sync_n;
  logic             run, locked, wrap, match;
  logic             ld_sec, ld_frac;
  logic [CNT_W-1:0] count;
  logic [SEC_W-1:0] alarm_sec;
  logic [FRAC_W-1:0] alarm_frac;
  logic [DATA_W-1:0] ctrl_word, stat_word, ien_word;

  ssc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign ld_sec  = wr_en & (wr_addr == A_SEC)  & ~locked;
  assign ld_frac = wr_en & (wr_addr == A_FRAC) & ~locked;

  ssc_tick_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .ld_sec(ld_sec),
    .ld_frac(ld_frac), .wdata(wr_data), .count(count), .wrap(wrap));

  ssc_alarm_unit #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_alm (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_asec(wr_en & (wr_addr == A_ASEC)),
    .wr_afrac(wr_en & (wr_addr == A_AFRAC)),
    .wdata(wr_data), .count(count), .alarm_sec(alarm_sec),
    .alarm_frac(alarm_frac), .match(match));

  ssc_ctrl_status #(.DATA_W(DATA_W)) u_cs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_ctrl(wr_en & (wr_addr == A_CTRL)),
    .wr_stat(wr_en & (wr_addr == A_STAT)),
    .wr_ien(wr_en & (wr_addr == A_IEN)),
    .ld_sec(ld_sec), .wdata(wr_data), .wrap(wrap), .match(match),
    .fault_in(fault_in), .run(run), .locked(locked),
    .ctrl_word(ctrl_word), .stat_word(stat_word), .ien_word(ien_word),
    .irq(alarm_irq));

  always_comb begin
    case (rd_addr)
      A_SEC:   rd_data = count[CNT_W-1:FRAC_W];
      A_FRAC:  rd_data = DATA_W'(count[FRAC_W-1:0]);
      A_ASEC:  rd_data = alarm_sec;
      A_AFRAC: rd_data = DATA_W'(alarm_frac);
      A_CTRL:  rd_data = ctrl_word;
      A_STAT:  rd_data = stat_word;
      A_IEN:   rd_data = ien_word;
      default: rd_data = '0;
    endcase
  end

  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (locked && wr_en && (wr_addr == A_SEC) && !run) |=> $stable(count)); // R5
endmodule

// File: tb/test_secure_sec_counter.sv
`timescale 1ns/1ps
module test_secure_sec_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        fault_in;
  logic        alarm_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  secure_sec_counter i_secure_sec_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .fault_in(fault_in), .alarm_irq(alarm_irq));

  // ---------------- behavioural reference model ----------------
  logic [46:0] m_cnt;
  logic [31:0] m_asec;
  logic [14:0] m_afrac;
  bit m_en, m_soft, m_hard, m_aie, m_nv, m_ovf, m_fail, m_alm, m_loaded;

  always @(posedge clk or negedge rst_n) begin
    bit lk, run, mt, wrp;
    logic [46:0] nc;
    logic [31:0] clr;
    if (!rst_n) begin
      m_cnt = '0; m_asec = '1; m_afrac = '0;
      m_en = 0; m_soft = 0; m_hard = 0; m_aie = 0;
      m_nv = 1; m_ovf = 0; m_fail = 0; m_alm = 0; m_loaded = 0;
    end else begin
      lk  = m_soft || m_hard;
      run = m_en && m_loaded && !m_nv && !m_ovf && !m_fail;
      mt  = (m_cnt == {m_asec, m_afrac}) && (m_asec != 32'hFFFF_FFFF);
      wrp = 0;
      nc  = m_cnt;
      clr = (wr_en && wr_addr == 5) ? wr_data : 32'h0;
      if (wr_en && wr_addr == 0 && !lk) nc = {wr_data, m_cnt[14:0]};
      else if (wr_en && wr_addr == 1 && !lk) nc = {m_cnt[46:15], wr_data[14:0]};
      else if (run) begin
        if (m_cnt == {47{1'b1}}) begin nc = '0; wrp = 1; end
        else nc = m_cnt + 47'd1;
      end
      if (wr_en && wr_addr == 0 && !lk && !m_nv) m_loaded = 1;
      m_alm  = mt  || (m_alm && !clr[4]);
      m_ovf  = wrp || (m_ovf && !clr[2]);
      m_nv   = m_nv && !clr[1];
      m_fail = fault_in || (m_fail && !clr[0]);
      if (wr_en && wr_addr == 4) begin
        if (!lk) m_en = wr_data[3];
        if (!m_hard) begin m_soft = wr_data[17]; m_hard = wr_data[18]; end
      end
      if (wr_en && wr_addr == 2) m_asec = wr_data;
      if (wr_en && wr_addr == 3) m_afrac = wr_data[14:0];
      if (wr_en && wr_addr == 6) m_aie = wr_data[4];
      m_cnt = nc;
    end
  end

  function automatic logic [31:0] model_rd(input int a);
    case (a)
      0: return m_cnt[46:15];
      1: return {17'h0, m_cnt[14:0]};
      2: return m_asec;
      3: return {17'h0, m_afrac};
      4: return {13'h0, m_hard, m_soft, 13'h0, m_en, 3'h0};
      5: return {27'h0, m_alm, 1'b0, m_ovf, m_nv, m_fail};
      6: return {27'h0, m_aie, 4'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0, 1: return "R2";
      2, 3: return "R6";
      4: return "R5";
      5: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic rdreg(input int a, output logic [31:0] v);
    rd_addr = a[2:0];
    #0.1;
    v = rd_data;
  endtask

  task automatic compare_all();
    logic [31:0] v;
    for (int a = 0; a < 7; a++) begin
      rdreg(a, v);
      chk(v, model_rd(a), tag_of(a));
    end
    chk({31'h0, alarm_irq}, {31'h0, m_alm && m_aie}, "R7 irq");
  endtask

  task automatic tick(input logic w, input logic [2:0] a, input logic [31:0] d);
    wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; fault_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);
    // R1 reset state
    rdreg(5, v); chk(v, 32'h2, "R1 status after reset");
    rdreg(2, v); chk(v, 32'hFFFF_FFFF, "R1 alarm seconds after reset");
    rdreg(0, v); chk(v, 32'h0, "R1 seconds after reset");
    rdreg(4, v); chk(v, 32'h0, "R1 control after reset");
    chk({31'h0, alarm_irq}, 32'h0, "R1 irq after reset");

    // R2: seconds written while invalid does not arm counting
    tick(1, 0, 32'd10); tick(1, 4, 32'h8); idle(5);
    rdreg(1, v); chk(v, 32'h0, "R2 held while invalid");
    tick(1, 5, 32'h2); idle(3);
    rdreg(1, v); chk(v, 32'h0, "R2 held until seconds rewritten");
    tick(1, 0, 32'd10); idle(20);
    rdreg(1, v); chk(v, 32'd20, "R2 fraction advanced once per clock");

    // R3 fraction load and carry into seconds
    tick(1, 1, 32'h7FFD); idle(3);
    rdreg(0, v); chk(v, 32'd11, "R3 carry into seconds");
    rdreg(1, v); chk(v, 32'h0, "R3 fraction after carry");

    // R2 disable holds; R8 zero write no effect
    tick(1, 4, 32'h0); rdreg(1, v); idle(5); rdreg(1, v2);
    chk(v2, v, "R2 disabled holds");
    tick(1, 5, 32'h0);
    rdreg(5, v); chk(v, 32'h0, "R8 zero write leaves flags");

    // R6/R7 alarm
    tick(1, 0, 32'd20); tick(1, 1, 32'h0);
    tick(1, 2, 32'd20); tick(1, 3, 32'd5); tick(1, 6, 32'h10);
    tick(1, 4, 32'h8); idle(8);
    rdreg(5, v); chk(v & 32'h10, 32'h10, "R6 alarm flag on match");
    chk({31'h0, alarm_irq}, 32'h1, "R7 irq with enable");
    tick(1, 6, 32'h0);
    chk({31'h0, alarm_irq}, 32'h0, "R7 irq masked");
    tick(1, 5, 32'h10);
    rdreg(5, v); chk(v & 32'h10, 32'h0, "R8 alarm flag cleared");

    // R9 fault halts
    fault_in = 1; idle(1); fault_in = 0;
    rdreg(1, v); idle(4); rdreg(1, v2);
    chk(v2, v, "R9 fault halts counting");
    rdreg(5, v); chk(v & 32'h1, 32'h1, "R9 fault flag set");
    tick(1, 5, 32'h1); idle(3);

    // R4 overflow with disarmed alarm on the way (R6)
    tick(1, 2, 32'hFFFF_FFFF); tick(1, 3, 32'h7FFE);
    tick(1, 0, 32'hFFFF_FFFF); tick(1, 1, 32'h7FFC); idle(6);
    rdreg(0, v); chk(v, 32'h0, "R4 seconds wrapped to zero");
    rdreg(1, v); chk(v, 32'h0, "R4 held at zero");
    rdreg(5, v); chk(v, 32'h4, "R4 overflow set, R6 disarmed alarm quiet");
    tick(1, 5, 32'h4); idle(3);
    rdreg(1, v); chk(v, 32'd3, "R4 resumes after clear");

    // R5 locks
    tick(1, 4, 32'h0002_0008); tick(1, 0, 32'd55);
    rdreg(0, v); chk(v, 32'h0, "R5 soft lock blocks seconds write");
    tick(1, 4, 32'h0);
    rdreg(4, v); chk(v, 32'h8, "R5 soft lock cleared, enable kept");
    tick(1, 4, 32'h0004_0008); tick(1, 4, 32'h0);
    rdreg(4, v); chk(v, 32'h0004_0008, "R5 hard lock sticky");
    tick(1, 1, 32'h0); tick(1, 0, 32'd7); idle(3);

    // R1 reset clears locks
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    idle(4);
    rdreg(4, v); chk(v, 32'h0, "R1 locks cleared by reset");
    rdreg(5, v); chk(v, 32'h2, "R1 invalid after second reset");

    done = 1;
    summary();
    $finish;
  end
endmodule